// File: doc/BRIEF.md
# Debug-Halt Peripheral Suspend Controller

This block decides which on-chip peripherals are switched off, both during normal running and while a debug breakpoint holds the core. Software sets a static shutdown register. A separate suspend-select register names the peripherals that should also be put to sleep only while the halt lasts. The block merges the two into one registered disable vector, with one line per peripheral.

Peripheral register traffic passes through a gate in the block. A disabled peripheral can still be read, so a debugger can inspect it. Writes to it are dropped, and so is the side-effect strobe that a read would normally raise (clear-on-read, FIFO pop). The CSR port reads back the shutdown register. While halted, that readback shows the suspend selections ORed in.

Bit 5 of the select register stands for the program flash. If that bit actually put the flash to sleep during a halt, the block raises a ramp-up-pending flag when the halt ends. The flag stays up until the flash controller reports that its ramp is done.

All pins are plain level or strobe signals. There is no valid/ready handshake: the CSR port and the peripheral access port each complete in a single cycle and never stall.

Top module: `dbg_susp_ctrl`

## Requirements
- R1: After reset, both 16-bit registers, the disable vector and the ramp-pending flag are 0.
- R2: The disable vector is the static shutdown register ORed with the select register gated by the halt input. It is registered, so it follows a change of the halt input or of either register one clock later.
- R3: A peripheral write raises the write-enable bit of the indexed peripheral only if that peripheral is not disabled. At most one write-enable bit is ever set.
- R4: A peripheral read always raises the select bit of the indexed peripheral. Its side-effect strobe is raised only if that peripheral is not disabled.
- R5: A CSR read of address 0 returns the shutdown register ORed with the select register while the registered halt is 1, and the shutdown register alone otherwise. Address 1 returns the select register.
- R6: The select register accepts writes at any time, including during a halt. A change made during a halt reaches the disable vector one clock later.
- R7: The ramp-pending flag is set on the clock where the registered halt is 1, the halt input is 0, and bit 5 of the select register was applied at any clock of that halt.
- R8: The ramp-pending flag clears on a ramp-done pulse. If set and clear fall on the same clock, set wins. Bit 5 of the shutdown register alone never sets the flag.
- R9: CSR addresses other than 0 and 1 read as 0, and writes to them change neither register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| halt_i | input | 1 | Breakpoint halt is active |
| ramp_done_i | input | 1 | Pulse from the flash: ramp-up has finished |
| csr_wr_i | input | 1 | CSR write strobe |
| csr_rd_i | input | 1 | CSR read strobe |
| csr_addr_i | input | 2 | CSR address (0 shutdown, 1 select) |
| csr_wdata_i | input | 16 | CSR write data |
| csr_rdata_o | output | 16 | CSR read data, same cycle as the strobe, 0 when not reading |
| pacc_idx_i | input | 4 | Index of the peripheral being accessed |
| pacc_wr_i | input | 1 | Peripheral write request |
| pacc_rd_i | input | 1 | Peripheral read request |
| psel_o | output | 16 | One-hot select of the accessed peripheral, for read-data muxing |
| pwr_en_o | output | 16 | Per-peripheral write enable after gating |
| prd_fx_o | output | 16 | Per-peripheral read side-effect strobe after gating |
| pdis_o | output | 16 | Registered per-peripheral disable |
| ramp_pend_o | output | 1 | Flash ramp-up is pending |

## Verification
The hardest case to reach is a flash-bit suspension that is applied only partway through a halt. In that case the select register is rewritten while halted, and the halt then ends on the same clock that a ramp-done pulse arrives. Directed sequences cover these cases: a write during the halt, an exit that coincides with ramp-done, and a shutdown-only flash bit. Long random stretches then follow, where halt toggles rarely enough that halts span many cycles with register writes and gated accesses inside them.

// File: rtl/dbg_susp_pkg.sv
package dbg_susp_pkg;
  localparam int CSR_AW      = 2;
  localparam logic [CSR_AW-1:0] ADDR_SHUT = 2'd0;
  localparam logic [CSR_AW-1:0] ADDR_SEL  = 2'd1;
endpackage

// File: rtl/susp_csr.sv
module susp_csr
  import dbg_susp_pkg::*;
#(
  parameter int N_PERIPH = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_i,
  input  logic                rd_i,
  input  logic [CSR_AW-1:0]   addr_i,
  input  logic [N_PERIPH-1:0] wdata_i,
  input  logic                halt_q_i,
  output logic [N_PERIPH-1:0] shut_o,
  output logic [N_PERIPH-1:0] sel_o,
  output logic [N_PERIPH-1:0] rdata_o
);
  logic [N_PERIPH-1:0] shut_q, sel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shut_q <= '0;
      sel_q  <= '0;
    end else if (wr_i) begin
      if (addr_i == ADDR_SHUT) shut_q <= wdata_i;
      if (addr_i == ADDR_SEL)  sel_q  <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (rd_i) begin
      if (addr_i == ADDR_SHUT)
        rdata_o = shut_q | (halt_q_i ? sel_q : '0);
      else if (addr_i == ADDR_SEL)
        rdata_o = sel_q;
    end
  end

  assign shut_o = shut_q;
  assign sel_o  = sel_q;

  // R5
  rdata_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rdata_o & ~(shut_q | sel_q)) == '0);

  // R9
  unmapped_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && addr_i != ADDR_SHUT && addr_i != ADDR_SEL) |=>
      ($stable(shut_q) && $stable(sel_q)));
endmodule

// File: rtl/susp_mask.sv
module susp_mask #(
  parameter int N_PERIPH = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                halt_i,
  input  logic [N_PERIPH-1:0] shut_i,
  input  logic [N_PERIPH-1:0] sel_i,
  output logic                halt_q_o,
  output logic [N_PERIPH-1:0] pdis_o
);
  logic [N_PERIPH-1:0] pdis_q;
  logic                halt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pdis_q <= '0;
      halt_q <= 1'b0;
    end else begin
      pdis_q <= shut_i | ({N_PERIPH{halt_i}} & sel_i);
      halt_q <= halt_i;
    end
  end

  assign pdis_o   = pdis_q;
  assign halt_q_o = halt_q;

  // R2
  dis_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pdis_q & ~($past(shut_i) | $past(sel_i))) == '0);

  // R2
  dis_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !halt_q |-> ((pdis_q & ~$past(shut_i)) == '0));
endmodule

// File: rtl/susp_gate.sv
module susp_gate #(
  parameter int N_PERIPH = 16,
  parameter int IDX_W    = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [IDX_W-1:0]    idx_i,
  input  logic                wr_i,
  input  logic                rd_i,
  input  logic [N_PERIPH-1:0] pdis_i,
  output logic [N_PERIPH-1:0] psel_o,
  output logic [N_PERIPH-1:0] pwr_en_o,
  output logic [N_PERIPH-1:0] prd_fx_o
);
  for (genvar p = 0; p < N_PERIPH; p++) begin : g_port
    logic hit;
    assign hit         = (idx_i == IDX_W'(p));
    assign psel_o[p]   = hit & (wr_i | rd_i);
    assign pwr_en_o[p] = hit & wr_i & ~pdis_i[p];
    assign prd_fx_o[p] = hit & rd_i & ~pdis_i[p];
  end

  // R3
  wr_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_en_o & pdis_i) == '0);

  // R3
  wr_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pwr_en_o));

  // R4
  fx_within_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (prd_fx_o & ~psel_o) == '0);
endmodule

// File: rtl/flash_ramp.sv
module flash_ramp #(
  parameter int N_PERIPH  = 16,
  parameter int FLASH_BIT = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                halt_i,
  input  logic                halt_q_i,
  input  logic [N_PERIPH-1:0] sel_i,
  input  logic                ramp_done_i,
  output logic                ramp_pend_o
);
  logic applied_q, pend_q, set_now;

  assign set_now = halt_q_i & ~halt_i & applied_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      applied_q <= 1'b0;
      pend_q    <= 1'b0;
    end else begin
      applied_q <= halt_i & (applied_q | sel_i[FLASH_BIT]);
      if (set_now)          pend_q <= 1'b1;
      else if (ramp_done_i) pend_q <= 1'b0;
    end
  end

  assign ramp_pend_o = pend_q;

  // R7
  ramp_on_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend_q) |-> ($past(halt_q_i) && !$past(halt_i)));

  // R8
  ramp_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pend_q) |-> $past(ramp_done_i));
endmodule

// File: rtl/dbg_susp_ctrl.sv
module dbg_susp_ctrl
  import dbg_susp_pkg::*;
#(
  parameter int N_PERIPH  = 16,
  parameter int FLASH_BIT = 5,
  parameter int IDX_W     = (N_PERIPH > 1) ? $clog2(N_PERIPH) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                halt_i,
  input  logic                ramp_done_i,
  input  logic                csr_wr_i,
  input  logic                csr_rd_i,
  input  logic [CSR_AW-1:0]   csr_addr_i,
  input  logic [N_PERIPH-1:0] csr_wdata_i,
  output logic [N_PERIPH-1:0] csr_rdata_o,
  input  logic [IDX_W-1:0]    pacc_idx_i,
  input  logic                pacc_wr_i,
  input  logic                pacc_rd_i,
  output logic [N_PERIPH-1:0] psel_o,
  output logic [N_PERIPH-1:0] pwr_en_o,
  output logic [N_PERIPH-1:0] prd_fx_o,
  output logic [N_PERIPH-1:0] pdis_o,
  output logic                ramp_pend_o
);
  logic [N_PERIPH-1:0] shut, sel;
  logic                halt_q;

  susp_csr #(.N_PERIPH(N_PERIPH)) u_csr (
    .clk(clk), .rst_n(rst_n), .wr_i(csr_wr_i), .rd_i(csr_rd_i),
    .addr_i(csr_addr_i), .wdata_i(csr_wdata_i), .halt_q_i(halt_q),
    .shut_o(shut), .sel_o(sel), .rdata_o(csr_rdata_o)
  );

  susp_mask #(.N_PERIPH(N_PERIPH)) u_mask (
    .clk(clk), .rst_n(rst_n), .halt_i(halt_i), .shut_i(shut),
    .sel_i(sel), .halt_q_o(halt_q), .pdis_o(pdis_o)
  );

  susp_gate #(.N_PERIPH(N_PERIPH), .IDX_W(IDX_W)) u_gate (
    .clk(clk), .rst_n(rst_n), .idx_i(pacc_idx_i), .wr_i(pacc_wr_i),
    .rd_i(pacc_rd_i), .pdis_i(pdis_o), .psel_o(psel_o),
    .pwr_en_o(pwr_en_o), .prd_fx_o(prd_fx_o)
  );

  flash_ramp #(.N_PERIPH(N_PERIPH), .FLASH_BIT(FLASH_BIT)) u_ramp (
    .clk(clk), .rst_n(rst_n), .halt_i(halt_i), .halt_q_i(halt_q),
    .sel_i(sel), .ramp_done_i(ramp_done_i), .ramp_pend_o(ramp_pend_o)
  );

  // R4
  rd_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pacc_rd_i && !pacc_wr_i) |-> $onehot(psel_o) || (int'(pacc_idx_i) >= N_PERIPH));
endmodule

// File: tb/tb_dbg_susp_ctrl.sv
`timescale 1ns/1ps
module tb_dbg_susp_ctrl;
  localparam int N = 16;
  localparam int FB = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic halt = 0, rdone = 0, cwr = 0, crd = 0, pwr = 0, prd = 0;
  logic [1:0]   caddr = '0;
  logic [N-1:0] cwdata = '0;
  logic [3:0]   pidx = '0;
  logic [N-1:0] crdata, psel, pwren, prdfx, pdis;
  logic         rpend;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [N-1:0] m_shut = 0, m_sel = 0, m_pdis = 0;
  logic m_hq = 0, m_fl = 0, m_ramp = 0;

  always #4 clk = ~clk;

  dbg_susp_ctrl dut (
    .clk(clk), .rst_n(rst_n), .halt_i(halt), .ramp_done_i(rdone),
    .csr_wr_i(cwr), .csr_rd_i(crd), .csr_addr_i(caddr), .csr_wdata_i(cwdata),
    .csr_rdata_o(crdata), .pacc_idx_i(pidx), .pacc_wr_i(pwr), .pacc_rd_i(prd),
    .psel_o(psel), .pwr_en_o(pwren), .prd_fx_o(prdfx), .pdis_o(pdis),
    .ramp_pend_o(rpend)
  );

  task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [N-1:0] exp_rdata();
    if (!crd) return '0;
    if (caddr == 2'd0) return m_shut | (m_hq ? m_sel : '0);
    if (caddr == 2'd1) return m_sel;
    return '0;
  endfunction

  function automatic logic [N-1:0] hot(input logic [3:0] i);
    return N'(1) << i;
  endfunction

  task automatic step(input logic h, input logic rd_done,
                      input logic w, input logic r, input logic [1:0] a,
                      input logic [N-1:0] d, input logic pw, input logic pr,
                      input logic [3:0] pi);
    @(negedge clk);
    halt = h; rdone = rd_done; cwr = w; crd = r; caddr = a; cwdata = d;
    pwr = pw; prd = pr; pidx = pi;
    #1;
    chk("R2", pdis, m_pdis);
    chk("R5", crdata, exp_rdata());
    chk("R3", pwren, pw ? (hot(pi) & ~m_pdis) : '0);
    chk("R4", psel, (pw | pr) ? hot(pi) : '0);
    chk("R4", prdfx, pr ? (hot(pi) & ~m_pdis) : '0);
    chk("R7", N'(rpend), N'(m_ramp));
    @(posedge clk);
    m_pdis = m_shut | (h ? m_sel : '0);
    if (m_hq && !h && m_fl) m_ramp = 1'b1;
    else if (rd_done) m_ramp = 1'b0;
    m_fl = h & (m_fl | m_sel[FB]);
    m_hq = h;
    if (w && a == 2'd0) m_shut = d;
    if (w && a == 2'd1) m_sel = d;
  endtask

  task automatic idle(input logic h);
    step(h, 0, 0, 0, 2'd0, '0, 0, 0, 4'd0);
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int unused;
    unused = $urandom(32'h1d5e);
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk("R1", pdis, '0);
    chk("R1", N'(rpend), '0);
    rst_n = 1'b1;
    step(0, 0, 0, 1, 2'd0, '0, 0, 0, 0);           // R1 shutdown reads 0
    step(0, 0, 0, 1, 2'd1, '0, 0, 0, 0);           // R1 select reads 0

    // static bits 0,1; select bits 2 and flash bit 5
    step(0, 0, 1, 0, 2'd0, 16'h0003, 0, 0, 0);
    step(0, 0, 1, 0, 2'd1, 16'h0024, 1, 0, 4'd2); // R3 write passes before halt
    step(0, 0, 0, 1, 2'd0, '0, 0, 1, 4'd1);        // R5 outside halt, R4 static block
    step(1, 0, 0, 1, 2'd0, '0, 1, 0, 4'd2);        // halt edge, pdis lags
    step(1, 0, 0, 1, 2'd0, '0, 1, 0, 4'd2);        // R3 blocked, R5 ORed
    step(1, 0, 0, 0, 2'd0, '0, 0, 1, 4'd5);        // R4 read of flash, no fx
    step(1, 0, 0, 0, 2'd0, '0, 1, 0, 4'd7);        // R3 unrelated passes
    step(0, 0, 0, 1, 2'd0, '0, 0, 0, 0);           // R7 exit sets ramp
    idle(0); idle(0);
    step(0, 1, 0, 0, 2'd0, '0, 0, 0, 0);           // R8 clear
    idle(0);

    // R8: shutdown flash bit alone never ramps
    step(0, 0, 1, 0, 2'd1, 16'h0000, 0, 0, 0);
    step(0, 0, 1, 0, 2'd0, 16'h0020, 0, 0, 0);
    idle(1); idle(1); idle(0); idle(0);

    // R6: select written during halt, then exit with ramp-done together
    step(0, 0, 1, 0, 2'd0, 16'h0000, 0, 0, 0);
    idle(1);
    step(1, 0, 1, 0, 2'd1, 16'h0020, 0, 0, 0);
    step(1, 0, 0, 1, 2'd0, '0, 1, 0, 4'd5);
    step(1, 0, 0, 1, 2'd0, '0, 1, 0, 4'd5);
    step(0, 1, 0, 0, 2'd0, '0, 0, 0, 0);           // R8 set wins
    idle(0);
    step(0, 1, 0, 0, 2'd0, '0, 0, 0, 0);
    idle(0);

    // R9 unmapped address
    step(0, 0, 1, 0, 2'd2, 16'hffff, 0, 0, 0);
    step(0, 0, 1, 0, 2'd3, 16'hffff, 0, 0, 0);
    step(0, 0, 0, 1, 2'd2, '0, 0, 0, 0);
    step(0, 0, 0, 1, 2'd0, '0, 0, 0, 0);
    step(0, 0, 0, 1, 2'd1, '0, 0, 0, 0);

    // constrained random
    begin
      logic h;
      h = 0;
      for (int i = 0; i < 4000; i++) begin
        if (($urandom % 16) == 0) h = ~h;
        step(h, ($urandom % 8) == 0, ($urandom % 5) == 0, ($urandom % 3) == 0,
             2'($urandom % 4), N'($urandom), ($urandom % 2) == 0,
             ($urandom % 2) == 0, 4'($urandom));
      end
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule